// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a synthesizable behavioural model of a single-clock synchronous static memory. It stores 36-bit words made of four 9-bit byte lanes, with a small, parameterized depth. All control, address and write data are captured on the rising clock edge. Read data passes through a registered pipeline and reaches the output one cycle after the access is issued. Each lane carries eight data bits and one parity bit.

Either of two load strobes starts an access. The processor strobe counts only while chip enable is asserted, and the cycle it starts is always a read. The controller strobe works regardless of chip enable and may start a write. After a load, a 2-bit burst counter walks four words in linear or interleaved order, or holds its position to suspend the burst. Writes are decoded from a global write, a byte-write gate and four lane selects.

Two states drive the control. `ST_DESEL` means no access is in progress. `ST_ACTIVE` means a burst is open. Any load moves to `ST_ACTIVE` when the chip is selected and to `ST_DESEL` when it is not. Cycles without a load keep the state: in `ST_ACTIVE` such a cycle is a burst continue or a suspend, and in `ST_DESEL` it is idle. Sleep freezes the state register.

Top module: `pbsram_core`

## Requirements
- R1: While reset is held and after it is released, the state is `ST_DESEL` and `dout_en` is 0.
- R2: The controller strobe `ld_ctl_n`=0 loads `addr` on any edge. The processor strobe `ld_cpu_n`=0 loads only when `chip_en_n`=0. While `chip_en_n`=1 the processor strobe is ignored, and the cycle acts as a continue or suspend.
- R3: A load selects the chip only if `chip_en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. A load that does not select the chip, and every later cycle until the next selecting load, issues no read, so `dout_en` stays 0.
- R4: A read issued at edge E places the word on `dout` with `dout_en`=1 after edge E+1, and it stays there until edge E+2.
- R5: With `ilv_mode`=0, each cycle with both strobes high and `step_n`=0 accesses the next word. Address bits [1:0] are the loaded value plus the step count modulo 4. After four steps the burst returns to the loaded word.
- R6: `ilv_mode` is captured only during reset. When it is 1, address bits [1:0] are the loaded value XOR the step count (0,1,2,3).
- R7: A cycle with both strobes high and `step_n`=1 during a burst accesses the same word again.
- R8: A cycle loaded by the processor strobe is a read whatever the write controls, including when the controller strobe is also low. The write controls are honoured on the next edge.
- R9: `wr_all_n`=0 writes all four lanes and overrides the other write inputs. Otherwise `wr_byte_n`=0 writes every lane k with `lane_sel_n[k]`=0. If both are 1, the cycle is a read. Lane k is `din[8k+7:8k]` plus `din[32+k]`.
- R10: A cycle that writes at least one lane issues no read, so `dout_en` is 0 after the following edge.
- R11: `drive_en_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge.
- R12: While `sleep`=1, no register or memory word changes and `dout_en` is 0. When `sleep` falls, the held output word reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ilv_mode | input | 1 | Burst order, captured in reset: 1 interleaved, 0 linear |
| sleep | input | 1 | Clock gate and output disable, active high |
| addr | input | AW | Word address |
| chip_en_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| ld_cpu_n | input | 1 | Processor load strobe, active low |
| ld_ctl_n | input | 1 | Controller load strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write gate, active low |
| lane_sel_n | input | 4 | Lane write selects, active low |
| drive_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data |
| dout | output | 36 | Read data |
| dout_en | output | 1 | High when `dout` should be driven |

## Verification
A burst counter that steps wrongly shows up as a wrong word on `dout` two edges after the faulty step. This covers a wrong order, a missed suspend or a wrong wrap. A wrong state register shows at the same point as a mismatch on `dout_en`: an output where none is expected, or a missing output. A write that lands in the wrong lane or at the wrong address surfaces only when that word is later read back. For that reason the bench compares every output cycle against a reference array that it keeps itself.

// File: rtl/pbsram_pkg.sv
`timescale 1ns/1ps
package pbsram_pkg;
    localparam int LANE_W  = 8;   // data bits per lane
    localparam int BURST_W = 2;   // burst position bits

    typedef enum logic [0:0] {
        ST_DESEL  = 1'b0,
        ST_ACTIVE = 1'b1
    } sel_state_e;

    // Position inside a four-word burst for a given start value and step count.
    function automatic logic [BURST_W-1:0] burst_pos(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] count,
        input logic               interleave
    );
        return interleave ? (start ^ count) : (start + count);
    endfunction
endpackage

// File: rtl/pbsram_burst.sv
`timescale 1ns/1ps
module pbsram_burst
    import pbsram_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               ilv_mode,
    input  logic               load,
    input  logic               step,
    input  logic [BURST_W-1:0] ld_pos,
    output logic [BURST_W-1:0] acc_pos
);
    logic               ilv_q;
    logic [BURST_W-1:0] start_q, start_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;

    always_comb begin
        start_d = load ? ld_pos : start_q;
        if (load)      cnt_d = '0;
        else if (step) cnt_d = cnt_q + 1'b1;
        else           cnt_d = cnt_q;
        acc_pos = burst_pos(start_d, cnt_d, ilv_q);
    end

    // Burst order is captured only while reset is held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ilv_q   <= ilv_mode;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (go) begin
            start_q <= start_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/pbsram_wrdec.sv
`timescale 1ns/1ps
module pbsram_wrdec #(
    parameter int NB = 4
) (
    input  logic          wr_all_n,
    input  logic          wr_byte_n,
    input  logic [NB-1:0] lane_sel_n,
    output logic [NB-1:0] lanes
);
    always_comb begin
        if (!wr_all_n)       lanes = '1;
        else if (!wr_byte_n) lanes = ~lane_sel_n;
        else                 lanes = '0;
    end
endmodule

// File: rtl/pbsram_array.sv
`timescale 1ns/1ps
module pbsram_array
    import pbsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic                    clk,
    input  logic                    go,
    input  logic [NB-1:0]           we,
    input  logic [AW-1:0]           wa,
    input  logic [NB*(LANE_W+1)-1:0] wd,
    input  logic                    re,
    input  logic [AW-1:0]           ra,
    output logic [NB*(LANE_W+1)-1:0] rd_q
);
    localparam int WW    = NB * (LANE_W + 1);
    localparam int PAR0  = NB * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (go) begin
            for (int k = 0; k < NB; k++) begin
                if (we[k]) begin
                    mem[wa][LANE_W*k +: LANE_W] <= wd[LANE_W*k +: LANE_W];
                    mem[wa][PAR0+k]             <= wd[PAR0+k];
                end
            end
            if (re) rd_q <= mem[ra];
        end
    end
endmodule

// File: rtl/pbsram_core.sv
`timescale 1ns/1ps
module pbsram_core
    import pbsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ilv_mode,
    input  logic                     sleep,
    input  logic [AW-1:0]            addr,
    input  logic                     chip_en_n,
    input  logic                     sel_hi,
    input  logic                     sel_lo_n,
    input  logic                     ld_cpu_n,
    input  logic                     ld_ctl_n,
    input  logic                     step_n,
    input  logic                     wr_all_n,
    input  logic                     wr_byte_n,
    input  logic [NB-1:0]            lane_sel_n,
    input  logic                     drive_en_n,
    input  logic [NB*(LANE_W+1)-1:0] din,
    output logic [NB*(LANE_W+1)-1:0] dout,
    output logic                     dout_en
);
    localparam int WW = NB * (LANE_W + 1);
    localparam int HW = AW - BURST_W;

    sel_state_e         st_q, st_d;
    logic               go, ld_cpu, ld, sel_now;
    logic               acc_act, step;
    logic [HW-1:0]      hi_q;
    logic [BURST_W-1:0] acc_pos;
    logic [AW-1:0]      acc_addr, ra_q;
    logic [NB-1:0]      lanes, we;
    logic               rd_issue, rd_pend_q, valid_q;

    assign go      = !sleep;
    assign ld_cpu  = !ld_cpu_n && !chip_en_n;
    assign ld      = ld_cpu || !ld_ctl_n;
    assign sel_now = !chip_en_n && sel_hi && !sel_lo_n;

    // Next-state and access decision
    always_comb begin
        st_d    = st_q;
        acc_act = 1'b0;
        step    = 1'b0;
        if (ld) begin
            st_d    = sel_now ? ST_ACTIVE : ST_DESEL;
            acc_act = sel_now;
        end else begin
            unique case (st_q)
                ST_DESEL:  acc_act = 1'b0;
                ST_ACTIVE: begin
                    acc_act = 1'b1;
                    step    = !step_n;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  st_q <= ST_DESEL;
        else if (go) st_q <= st_d;
    end

    pbsram_burst u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .ilv_mode (ilv_mode),
        .load     (ld),
        .step     (step),
        .ld_pos   (addr[BURST_W-1:0]),
        .acc_pos  (acc_pos)
    );

    pbsram_wrdec #(.NB(NB)) u_wrdec (
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_sel_n (lane_sel_n),
        .lanes      (lanes)
    );

    assign acc_addr = {(ld ? addr[AW-1:BURST_W] : hi_q), acc_pos};
    assign we       = (acc_act && !ld_cpu) ? lanes : '0;
    assign rd_issue = acc_act && (we == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            ra_q      <= '0;
            rd_pend_q <= 1'b0;
            valid_q   <= 1'b0;
        end else if (go) begin
            if (ld) hi_q <= addr[AW-1:BURST_W];
            ra_q      <= acc_addr;
            rd_pend_q <= rd_issue;
            valid_q   <= rd_pend_q;
        end
    end

    pbsram_array #(.AW(AW), .NB(NB)) u_array (
        .clk  (clk),
        .go   (go),
        .we   (we),
        .wa   (acc_addr),
        .wd   (din),
        .re   (rd_pend_q),
        .ra   (ra_q),
        .rd_q (dout)
    );

    // Output process
    always_comb begin
        dout_en = valid_q && !drive_en_n && !sleep;
    end

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(st_q) && $stable(valid_q) && $stable(dout))); // R12
    AST_SUSPEND_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ld && st_q == ST_ACTIVE && step_n) |-> (acc_addr == ra_q)); // R7
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ld && st_q == ST_DESEL) |=> !rd_pend_q); // R3
    AST_OUT_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(rd_pend_q)); // R4
    AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (go && lanes != '0 && acc_act && !ld_cpu) |=> !rd_pend_q); // R10
    AST_CPU_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ld_cpu && sel_now) |=> rd_pend_q); // R8
endmodule

// File: tb/pbsram_core_tb_top.sv
`timescale 1ns/1ps
module pbsram_core_tb_top;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ilv_mode = 1'b0;
    logic        sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        chip_en_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
    logic        ld_cpu_n = 1'b1, ld_ctl_n = 1'b1, step_n = 1'b1;
    logic        wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [3:0]  lane_sel_n = 4'hF;
    logic        drive_en_n = 1'b0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_en;

    pbsram_core #(.AW(AW), .NB(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ilv_mode(ilv_mode), .sleep(sleep),
        .addr(addr), .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
        .drive_en_n(drive_en_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference state
    logic [35:0] rmem [64];
    bit          r_act = 0;
    logic [5:0]  r_base = '0;
    logic [1:0]  r_cnt = '0;
    bit          r_ilv = 0;

    // Scoreboard queues
    int          q_due[$];
    bit          q_en[$];
    logic [35:0] q_dat[$];
    string       q_tag[$];

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [35:0] pat(input int i);
        return {i[3:0], 32'h5A5A_0000 ^ (i * 32'h0001_0101)};
    endfunction

    // Driver: drives one edge's inputs and pushes the expected output.
    task automatic cyc_in(input bit pn = 1, input bit cn = 1, input bit cen = 0,
                          input bit c0 = 1, input bit c1n = 0, input bit adv = 1,
                          input bit gw = 1, input bit bw = 1, input logic [3:0] bs = 4'hF,
                          input logic [5:0] a = '0, input logic [35:0] d = '0,
                          input string tag = "R4");
        bit lp, ld, sl, act;
        logic [5:0] acc;
        logic [3:0] wb;
        @(negedge clk);
        ld_cpu_n = pn; ld_ctl_n = cn; chip_en_n = cen; sel_hi = c0; sel_lo_n = c1n;
        step_n = adv; wr_all_n = gw; wr_byte_n = bw; lane_sel_n = bs; addr = a; din = d;
        lp = !pn && !cen;
        ld = lp || !cn;
        sl = !cen && c0 && !c1n;
        if (ld) begin
            r_act = sl; r_base = a; r_cnt = '0; act = sl; acc = a;
        end else begin
            act = r_act;
            if (r_act && !adv) r_cnt = r_cnt + 2'd1;
            acc = {r_base[5:2], (r_ilv ? (r_base[1:0] ^ r_cnt) : (r_base[1:0] + r_cnt))};
        end
        wb = !gw ? 4'hF : (!bw ? ~bs : 4'h0);
        if (lp) wb = 4'h0;
        if (act && wb != 4'h0) begin
            for (int k = 0; k < 4; k++) begin
                if (wb[k]) begin
                    rmem[acc][8*k +: 8] = d[8*k +: 8];
                    rmem[acc][32+k]     = d[32+k];
                end
            end
        end
        q_due.push_back(cyc + 2);
        q_en.push_back(act && wb == 4'h0);
        q_dat.push_back((act && wb == 4'h0) ? rmem[acc] : 36'h0);
        q_tag.push_back(tag);
    endtask

    // Monitor
    always @(negedge clk) begin
        #1;
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            bit          e;
            logic [35:0] x;
            string       t;
            e = q_en.pop_front() && !drive_en_n;
            x = q_dat.pop_front();
            t = q_tag.pop_front();
            void'(q_due.pop_front());
            chk(dout_en == e, t, {35'h0, dout_en}, {35'h0, e});
            if (e) chk(dout === x, t, dout, x);
        end
    end

    task automatic flush();
        cyc_in(.cn(0), .c0(0), .tag("R3"));
        repeat (2) cyc_in(.adv(0), .tag("R3"));
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dout_en == 1'b0, "R1", {35'h0, dout_en}, 36'h0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(dout_en == 1'b0, "R1", {35'h0, dout_en}, 36'h0);

        // R9/R10: single global writes fill words 0..15
        for (int i = 0; i < 16; i++) cyc_in(.cn(0), .gw(0), .a(6'(i)), .d(pat(i)), .tag("R10"));

        // R5: linear burst write from 9, then burst read with wrap
        cyc_in(.cn(0), .gw(0), .a(6'd9), .d(36'hA_1111_0009), .tag("R5"));
        cyc_in(.adv(0), .gw(0), .d(36'hB_2222_000A), .tag("R5"));
        cyc_in(.adv(0), .gw(0), .d(36'hC_3333_000B), .tag("R5"));
        cyc_in(.adv(0), .gw(0), .d(36'hD_4444_0008), .tag("R5"));
        cyc_in(.pn(0), .a(6'd9), .tag("R5"));
        repeat (4) cyc_in(.adv(0), .tag("R5"));

        // R7: suspend then continue
        cyc_in(.pn(0), .a(6'd4), .tag("R7"));
        repeat (2) cyc_in(.adv(1), .tag("R7"));
        cyc_in(.adv(0), .tag("R7"));

        // R11: output enable high hides data
        drive_en_n = 1'b1;
        repeat (3) cyc_in(.adv(0), .tag("R11"));
        drive_en_n = 1'b0;
        repeat (2) cyc_in(.adv(1), .tag("R11"));

        // R8: processor load with write controls low is a read; write lands next edge
        cyc_in(.pn(0), .cn(0), .gw(0), .a(6'd12), .d(36'hE_DEAD_BEEF), .tag("R8"));
        cyc_in(.gw(0), .adv(1), .d(36'h7_0C0F_FEE0), .tag("R8"));
        cyc_in(.pn(0), .a(6'd12), .tag("R8"));

        // R9: lane writes, gate high ignores selects, global overrides selects
        cyc_in(.cn(0), .bw(0), .bs(4'b1010), .a(6'd2), .d(36'hF_FFFF_FFFF), .tag("R9"));
        cyc_in(.pn(0), .a(6'd2), .tag("R9"));
        cyc_in(.cn(0), .bw(1), .bs(4'b0000), .a(6'd2), .d(36'h0), .tag("R9"));
        cyc_in(.cn(0), .gw(0), .bw(0), .bs(4'b1110), .a(6'd3), .d(36'h9_8765_4321), .tag("R9"));
        cyc_in(.pn(0), .a(6'd3), .tag("R9"));

        // R2: processor strobe ignored while chip enable high
        cyc_in(.pn(0), .cen(1), .adv(1), .a(6'd7), .tag("R2"));
        // R3: deselecting load via each select input, then idle continues
        cyc_in(.cn(0), .c0(0), .tag("R3"));
        cyc_in(.adv(0), .tag("R3"));
        cyc_in(.cn(0), .a(6'd5), .tag("R3"));
        cyc_in(.cn(0), .c1n(1), .tag("R3"));
        cyc_in(.adv(0), .tag("R3"));
        cyc_in(.cn(0), .cen(1), .tag("R3"));
        cyc_in(.adv(0), .tag("R3"));

        // R12: sleep freezes state and memory
        cyc_in(.pn(0), .a(6'd3), .tag("R12"));
        cyc_in(.cn(0), .c0(0), .tag("R12"));
        @(negedge clk); #3;
        sleep = 1'b1; ld_ctl_n = 1'b0; wr_all_n = 1'b0; addr = 6'd3; din = 36'h1_2345_6789;
        #1 chk(dout_en == 1'b0, "R12", {35'h0, dout_en}, 36'h0);
        repeat (3) begin
            @(negedge clk); #2;
            chk(dout_en == 1'b0, "R12", {35'h0, dout_en}, 36'h0);
        end
        @(negedge clk);
        sleep = 1'b0; ld_ctl_n = 1'b1; wr_all_n = 1'b1;
        #2;
        chk(dout_en == 1'b1, "R12", {35'h0, dout_en}, 36'h1);
        chk(dout === rmem[3], "R12", dout, rmem[3]);
        cyc_in(.pn(0), .a(6'd3), .tag("R12"));
        flush();

        // R6: interleaved order after reset
        ilv_mode = 1'b1;
        rst_n = 1'b0;
        r_ilv = 1; r_act = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2 chk(dout_en == 1'b0, "R1", {35'h0, dout_en}, 36'h0);
        cyc_in(.pn(0), .a(6'd10), .tag("R6"));
        repeat (4) cyc_in(.adv(0), .tag("R6"));
        cyc_in(.pn(0), .a(6'd13), .tag("R6"));
        repeat (3) cyc_in(.adv(0), .tag("R6"));
        cyc_in(.cn(0), .gw(0), .a(6'd7), .d(36'h3_3333_0007), .tag("R6"));
        cyc_in(.adv(0), .gw(0), .d(36'h6_6666_0006), .tag("R6"));
        cyc_in(.pn(0), .a(6'd7), .tag("R6"));
        cyc_in(.adv(0), .tag("R6"));
        flush();

        finish_run();
    end
endmodule